// File: doc/BRIEF.md
# Two-Bank Interleaved Byte Memory

This block is a 16-bit data store built from two byte-wide banks. Byte addresses are interleaved on the low-order bit, so every even byte lives in bank 0 and every odd byte lives in bank 1. Both bytes of a halfword at an even address therefore sit in the same local row of the two banks and move in a single clock. A byte access may name any address and touches only its own bank. A halfword at an odd address would need two different rows. It is refused: storage is left untouched and an error flag is raised.

The order of the two bytes inside a halfword is fixed at build time by the `BIG_ENDIAN` parameter. With `BIG_ENDIAN=1` the byte at the lower address carries bits 15:8. With `BIG_ENDIAN=0` it carries bits 7:0. Reads use the same convention as writes.

A small response state machine records what each request was and drives the outputs one clock later. Its states are: `S_IDLE` (no response pending), `S_RDATA` (an aligned read is being returned), `S_WACK` (an aligned write is being acknowledged) and `S_FAULT` (a misaligned access was refused). In every state the next state follows one rule:
- no request goes to `S_IDLE`;
- a misaligned request goes to `S_FAULT`;
- an aligned write goes to `S_WACK`;
- an aligned read goes to `S_RDATA`.

Top module: `ilv_mem`

## Requirements
- R1: While reset is held and at the first sample after it is released, `rvalid`, `misaligned` and `rdata` are all zero.
- R2: `rvalid` is high for exactly the one cycle after each cycle with `req` high, and low after every cycle with `req` low.
- R3: A byte access (`size`=0) at any address A reaches only the byte at A: bank A[0], row A[AW-1:1]. A byte read returns that byte in `rdata[7:0]` with `rdata[15:8]`=0.
- R4: With `BIG_ENDIAN`=1, an aligned halfword write of W at even address A places W[15:8] at byte A and W[7:0] at byte A+1. For example, 0xA1B2 puts 0xA1 in bank 0 and 0xB2 in bank 1.
- R5: With `BIG_ENDIAN`=0, an aligned halfword write of W at even address A places W[7:0] at byte A and W[15:8] at byte A+1.
- R6: An aligned halfword read (`size`=1, A even) returns both bytes of row A[AW-1:1], assembled with the same byte order that R4 or R5 uses for writes.
- R7: A halfword access at an odd address raises `misaligned` together with `rvalid` one cycle later, returns `rdata`=0, and modifies no stored byte.
- R8: Every byte access, and every halfword access at an even address, answers with `misaligned`=0.
- R9: The response to any write has `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the response logic |
| req | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 1 | 0 = byte, 1 = halfword |
| addr | input | AW | Global byte address |
| wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| rdata | output | 16 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Response strobe, one cycle after `req` |
| misaligned | output | 1 | The access just answered was refused |

## Verification
The assertions assume that `req`, `we`, `size` and `addr` are stable across each rising edge. They also assume that a read only means something once its bytes have been written, because the banks are never cleared. The bench drives every input on the falling edge and writes the whole byte space before its first read. It then sweeps every address of a 64-byte build with byte, aligned and misaligned accesses in both byte orders, and compares against byte arrays that it updates from the requirements.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_HALF = 1'b1
    } acc_size_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RDATA = 2'd1,
        S_WACK  = 2'd2,
        S_FAULT = 2'd3
    } rsp_state_e;

    typedef struct packed {
        logic half;
        logic lane;
    } rd_ctx_t;

endpackage

// File: rtl/ilv_addr_decode.sv
module ilv_addr_decode #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic          half,
    output logic [AW-2:0] row,
    output logic          lane,
    output logic          misal
);
    always_comb begin
        lane  = addr[0];
        row   = addr[AW-1:1];
        // An odd halfword would straddle two rows.
        misal = half & addr[0];
    end
endmodule

// File: rtl/ilv_lane_steer.sv
module ilv_lane_steer #(
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic        wr,
    input  logic        wr_half,
    input  logic        wr_lane,
    input  logic [15:0] wdata,
    input  logic        rd_half,
    input  logic        rd_lane,
    input  logic [7:0]  b0_q,
    input  logic [7:0]  b1_q,
    output logic        we0,
    output logic        we1,
    output logic [7:0]  wd0,
    output logic [7:0]  wd1,
    output logic [15:0] rd16
);
    logic [7:0] lo_addr_w;
    logic [7:0] hi_addr_w;
    logic [15:0] half_rd;

    generate
        if (BIG_ENDIAN) begin : g_big
            always_comb begin
                lo_addr_w = wdata[15:8];
                hi_addr_w = wdata[7:0];
                half_rd   = {b0_q, b1_q};
            end
        end else begin : g_little
            always_comb begin
                lo_addr_w = wdata[7:0];
                hi_addr_w = wdata[15:8];
                half_rd   = {b1_q, b0_q};
            end
        end
    endgenerate

    always_comb begin
        if (wr_half) begin
            we0 = wr;
            we1 = wr;
            wd0 = lo_addr_w;
            wd1 = hi_addr_w;
        end else begin
            we0 = wr & ~wr_lane;
            we1 = wr & wr_lane;
            wd0 = wdata[7:0];
            wd1 = wdata[7:0];
        end
        if (rd_half) rd16 = half_rd;
        else         rd16 = {8'h00, (rd_lane ? b1_q : b0_q)};
    end
endmodule

// File: rtl/ilv_byte_bank.sv
module ilv_byte_bank #(
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [ROW_W-1:0] row,
    input  logic [7:0]       wd,
    output logic [7:0]       rd_q
);
    localparam int ROWS = 1 << ROW_W;

    logic [7:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (we) cells[row] <= wd;
        if (re) rd_q <= cells[row];
    end
endmodule

// File: rtl/ilv_mem.sv
module ilv_mem #(
    parameter int AW         = 8,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic          size,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata,
    output logic          rvalid,
    output logic          misaligned
);
    import ilv_pkg::*;

    localparam int ROW_W = AW - 1;
    localparam int NBANK = 2;

    rsp_state_e state_q, state_d;
    rd_ctx_t    ctx_q;
    acc_size_e  acc_sz;

    logic [ROW_W-1:0] row;
    logic             lane;
    logic             misal;
    logic             wr_go;
    logic             rd_go;
    logic [15:0]      steer_rd;
    logic             bank_we [NBANK];
    logic [7:0]       bank_wd [NBANK];
    logic [7:0]       bank_rd [NBANK];

    assign acc_sz = acc_size_e'(size);

    ilv_addr_decode #(.AW(AW)) u_dec (
        .addr  (addr),
        .half  (acc_sz == SZ_HALF),
        .row   (row),
        .lane  (lane),
        .misal (misal)
    );

    assign wr_go = req & we & ~misal;
    assign rd_go = req & ~we & ~misal;

    ilv_lane_steer #(.BIG_ENDIAN(BIG_ENDIAN)) u_steer (
        .wr      (wr_go),
        .wr_half (acc_sz == SZ_HALF),
        .wr_lane (lane),
        .wdata   (wdata),
        .rd_half (ctx_q.half),
        .rd_lane (ctx_q.lane),
        .b0_q    (bank_rd[0]),
        .b1_q    (bank_rd[1]),
        .we0     (bank_we[0]),
        .we1     (bank_we[1]),
        .wd0     (bank_wd[0]),
        .wd1     (bank_wd[1]),
        .rd16    (steer_rd)
    );

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            ilv_byte_bank #(.ROW_W(ROW_W)) u_bank (
                .clk  (clk),
                .we   (bank_we[b]),
                .re   (rd_go),
                .row  (row),
                .wd   (bank_wd[b]),
                .rd_q (bank_rd[b])
            );
        end
    endgenerate

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ctx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (rd_go) begin
                ctx_q.half <= (acc_sz == SZ_HALF);
                ctx_q.lane <= lane;
            end
        end
    end

    // Next-state logic: every state follows the same rule
    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_IDLE, S_RDATA, S_WACK, S_FAULT: begin
                if (!req)       state_d = S_IDLE;
                else if (misal) state_d = S_FAULT;
                else if (we)    state_d = S_WACK;
                else            state_d = S_RDATA;
            end
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        rvalid     = 1'b0;
        misaligned = 1'b0;
        rdata      = 16'h0000;
        unique case (state_q)
            S_IDLE:  ;
            S_RDATA: begin
                rvalid = 1'b1;
                rdata  = steer_rd;
            end
            S_WACK:  rvalid = 1'b1;
            S_FAULT: begin
                rvalid     = 1'b1;
                misaligned = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic          we,
    input logic          size,
    input logic [AW-1:0] addr,
    input logic [15:0]   rdata,
    input logic          rvalid,
    input logic          misaligned
);
    logic odd_half;
    assign odd_half = size & addr[0];

    always @(negedge clk)
        if (!rst_n) AST_RESET_QUIET: assert (!rvalid && !misaligned && rdata == 16'h0); // R1

    AST_REQ_ANSWERED:  assert property (@(posedge clk) disable iff (!rst_n) req |=> rvalid);                            // R2
    AST_NO_SPURIOUS:   assert property (@(posedge clk) disable iff (!rst_n) !req |=> !rvalid);                          // R2
    AST_BYTE_ZEXT:     assert property (@(posedge clk) disable iff (!rst_n) (req && !we && !size) |=> rdata[15:8] == 8'h0); // R3
    AST_MISAL_FLAG:    assert property (@(posedge clk) disable iff (!rst_n) (req && odd_half) |=> (misaligned && rvalid));   // R7
    AST_MISAL_ZERO:    assert property (@(posedge clk) disable iff (!rst_n) misaligned |-> rdata == 16'h0);            // R7
    AST_ALIGNED_OK:    assert property (@(posedge clk) disable iff (!rst_n) (req && !odd_half) |=> !misaligned);        // R8
    AST_WRITE_ZERO:    assert property (@(posedge clk) disable iff (!rst_n) (req && we) |=> rdata == 16'h0);            // R9
endmodule

bind ilv_mem ilv_mem_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .we         (we),
    .size       (size),
    .addr       (addr),
    .rdata      (rdata),
    .rvalid     (rvalid),
    .misaligned (misaligned)
);

// File: tb/ilv_mem_tb.sv
module ilv_mem_tb;
    localparam int AW    = 6;
    localparam int BYTES = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic          size = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rd_be, rd_le;
    logic          rv_be, rv_le, mis_be, mis_le;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [7:0] m_be [BYTES];
    logic [7:0] m_le [BYTES];

    always #10 clk = ~clk;

    ilv_mem #(.AW(AW), .BIG_ENDIAN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .addr(addr),
        .wdata(wdata), .rdata(rd_be), .rvalid(rv_be), .misaligned(mis_be));

    ilv_mem #(.AW(AW), .BIG_ENDIAN(1'b0)) u_dut_le (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .addr(addr),
        .wdata(wdata), .rdata(rd_le), .rvalid(rv_le), .misaligned(mis_le));

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("[TB] FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access; outputs are sampled at the falling edge after the capturing rising edge.
    task automatic access(input logic w, input logic s, input int a, input logic [15:0] d);
        @(negedge clk);
        req = 1'b1; we = w; size = s; addr = a[AW-1:0]; wdata = d;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic check_rsp(input string tag, input logic mis, input logic [15:0] e_be, input logic [15:0] e_le);
        check({tag, " R2 rvalid be"}, {15'h0, rv_be}, 16'h1);
        check({tag, " R2 rvalid le"}, {15'h0, rv_le}, 16'h1);
        check({tag, " flag be"}, {15'h0, mis_be}, {15'h0, mis});
        check({tag, " flag le"}, {15'h0, mis_le}, {15'h0, mis});
        check({tag, " rdata be"}, rd_be, e_be);
        check({tag, " rdata le"}, rd_le, e_le);
    endtask

    function automatic logic [7:0] pat(input int a, input int k);
        return 8'((a * 37 + k * 91 + 5) & 8'hFF);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("[TB] FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check("R1 rvalid in reset", {15'h0, rv_be | rv_le}, 16'h0);
        check("R1 flag in reset", {15'h0, mis_be | mis_le}, 16'h0);
        check("R1 rdata in reset", rd_be | rd_le, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rvalid after reset", {15'h0, rv_be | rv_le}, 16'h0);
        check("R1 rdata after reset", rd_be | rd_le, 16'h0);

        // Fill every byte (R3, R8, R9)
        for (int a = 0; a < BYTES; a++) begin
            access(1'b1, 1'b0, a, {8'hEE, pat(a, 0)});
            m_be[a] = pat(a, 0);
            m_le[a] = pat(a, 0);
            check_rsp("R3 R8 R9 byte write", 1'b0, 16'h0, 16'h0);
        end
        @(negedge clk);
        check("R2 idle rvalid", {15'h0, rv_be | rv_le}, 16'h0);

        // Byte read sweep (R3)
        for (int a = 0; a < BYTES; a++) begin
            access(1'b0, 1'b0, a, 16'hFFFF);
            check_rsp("R3 byte read", 1'b0, {8'h0, m_be[a]}, {8'h0, m_le[a]});
        end

        // Lone byte write touches only its own byte (R3)
        access(1'b1, 1'b0, 9, 16'h005A);
        m_be[9] = 8'h5A; m_le[9] = 8'h5A;
        access(1'b0, 1'b0, 8, 16'h0);
        check_rsp("R3 neighbour untouched", 1'b0, {8'h0, m_be[8]}, {8'h0, m_le[8]});
        access(1'b0, 1'b0, 9, 16'h0);
        check_rsp("R3 target written", 1'b0, 16'h005A, 16'h005A);

        // Known example 0xA1B2 (R4, R5)
        access(1'b1, 1'b1, 4, 16'hA1B2);
        m_be[4] = 8'hA1; m_be[5] = 8'hB2;
        m_le[4] = 8'hB2; m_le[5] = 8'hA1;
        check_rsp("R9 half write", 1'b0, 16'h0, 16'h0);
        access(1'b0, 1'b0, 4, 16'h0);
        check_rsp("R4 R5 low byte", 1'b0, 16'h00A1, 16'h00B2);
        access(1'b0, 1'b0, 5, 16'h0);
        check_rsp("R4 R5 high byte", 1'b0, 16'h00B2, 16'h00A1);
        access(1'b0, 1'b1, 4, 16'h0);
        check_rsp("R6 half read A1B2", 1'b0, 16'hA1B2, 16'hA1B2);

        // Halfword sweep over all even addresses (R4, R5, R6)
        for (int a = 0; a < BYTES; a += 2) begin
            logic [15:0] w;
            w = {pat(a, 1), pat(a, 2)};
            access(1'b1, 1'b1, a, w);
            m_be[a] = w[15:8]; m_be[a+1] = w[7:0];
            m_le[a] = w[7:0];  m_le[a+1] = w[15:8];
            check_rsp("R8 R9 half write", 1'b0, 16'h0, 16'h0);
        end
        for (int a = 0; a < BYTES; a++) begin
            access(1'b0, 1'b0, a, 16'h0);
            check_rsp("R4 R5 byte placement", 1'b0, {8'h0, m_be[a]}, {8'h0, m_le[a]});
        end
        for (int a = 0; a < BYTES; a += 2) begin
            access(1'b0, 1'b1, a, 16'h0);
            check_rsp("R6 half read", 1'b0, {m_be[a], m_be[a+1]}, {m_le[a+1], m_le[a]});
        end

        // Misaligned halfwords: flagged, zero data, storage untouched (R7)
        for (int a = 1; a < BYTES; a += 2) begin
            access(1'b1, 1'b1, a, 16'hDEAD);
            check_rsp("R7 odd half write", 1'b1, 16'h0, 16'h0);
            access(1'b0, 1'b1, a, 16'h0);
            check_rsp("R7 odd half read", 1'b1, 16'h0, 16'h0);
        end
        for (int a = 0; a < BYTES; a++) begin
            access(1'b0, 1'b0, a, 16'h0);
            check_rsp("R7 storage unchanged", 1'b0, {8'h0, m_be[a]}, {8'h0, m_le[a]});
        end

        // Back-to-back requests (R2)
        @(negedge clk);
        req = 1'b1; we = 1'b0; size = 1'b1; addr = 6'd2;
        @(negedge clk);
        check("R2 back-to-back first", {15'h0, rv_be}, 16'h1);
        addr = 6'd3;
        @(negedge clk);
        check("R2 back-to-back second", {15'h0, rv_be & mis_be}, 16'h1);
        req = 1'b0;
        @(negedge clk);
        check("R2 drop after stream", {15'h0, rv_be | rv_le}, 16'h0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule